// File: doc/BRIEF.md
# Byte-Addressable Data Memory

This block is the data store of a 32-bit single-cycle processor whose program memory is kept apart. Every address names one 8-bit location, so a 32-bit word covers four neighbouring addresses. The processor presents an address, write data and two write controls. One control stores a whole aligned word and the other stores a single byte. When neither control is raised, the word that holds the addressed byte appears on the read port in the same cycle.

Words are stored big-endian: the lowest address of a word holds its most significant byte. A word access (read or write) whose address is not a multiple of four raises a fault flag at once, so the pipeline can report a bus error. A faulting word write leaves the storage untouched. Only the low address bits that cover the parameterised depth select storage, so higher addresses alias. Writes take effect on the rising clock edge. The storage clears while reset is applied.

Top module: `bytemem`

## Requirements
- R1: After reset, a read at any address returns 0x00000000.
- R2: With wr_word=0 and wr_byte=0, rd_data combinationally shows the four bytes starting at the address with bits [1:0] cleared, big-endian: the byte at offset 0 on rd_data[31:24] and the byte at offset 3 on rd_data[7:0]. This holds even when bits [1:0] are nonzero.
- R3: wr_word=1 at an address with bits [1:0]=00 stores wr_data at the rising edge: wr_data[31:24] to offset 0, and on through wr_data[7:0] to offset 3.
- R4: wr_byte=1 with wr_word=0 stores wr_data[7:0] at the one addressed byte, at any offset, at the rising edge. The other three bytes of that word keep their values.
- R5: mis_align is 1 exactly when address bits [1:0] are nonzero and either wr_word=1 or both write controls are 0. It is 0 during a byte write (wr_byte=1, wr_word=0).
- R6: A word write with address bits [1:0] nonzero changes no stored byte.
- R7: With wr_word=1 and wr_byte=1 together, the word write is performed and the byte write is not.
- R8: Only the low log2(DEPTH_BYTES) address bits select storage. Two addresses that differ only above those bits reach the same byte.
- R9: While rst_n is low, writes have no effect. Reset is applied asynchronously and released on the second rising edge after rst_n goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 32 | Byte address |
| wr_data | input | 32 | Write data; only [7:0] is used for byte writes |
| wr_word | input | 1 | Store a full aligned word |
| wr_byte | input | 1 | Store the low byte at the addressed location |
| rd_data | output | 32 | Word containing the addressed byte, big-endian |
| mis_align | output | 1 | Word access at an address that is not a multiple of four |

## Verification
Two results are due in the same cycle as their stimulus: rd_data and mis_align are combinational from the address, the controls and the current contents. Stored values appear only after the next rising edge. The bench therefore drives inputs at the falling edge and compares rd_data and mis_align 1 ns later. It applies the write to its own byte model at the rising edge, so the next read sees the updated contents. After reset release the bench waits four edges before issuing any operation, which covers the two-stage release.

// File: rtl/bytemem_pkg.sv
package bytemem_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WORD  = 2'd1,
    ACC_BYTE  = 2'd2
  } acc_e;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/bytemem_rst_sync.sv
module bytemem_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/bytemem_ctrl.sv
module bytemem_ctrl
  import bytemem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic [IDX_W-1:0]                  addr_lo,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic                              wr_word,
  input  logic                              wr_byte,
  output logic [IDX_W-$clog2(DATA_W/BYTE_W)-1:0] row,
  output logic [DATA_W/BYTE_W-1:0]          lane_we,
  output logic [DATA_W/BYTE_W-1:0][BYTE_W-1:0] lane_data,
  output logic                              mis_align
);

  localparam int LANES  = DATA_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);

  acc_e              acc;
  logic [LANE_W-1:0] ofs;
  logic              aligned;

  assign ofs     = addr_lo[LANE_W-1:0];
  assign row     = addr_lo[IDX_W-1:LANE_W];
  assign aligned = (ofs == '0);

  // word control has priority over byte control
  always_comb begin
    if (wr_word)      acc = ACC_WORD;
    else if (wr_byte) acc = ACC_BYTE;
    else              acc = ACC_READ;
  end

  assign mis_align = (acc != ACC_BYTE) && !aligned;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      lane_we[l]   = 1'b0;
      lane_data[l] = wr_data[BYTE_W-1:0];
      unique case (acc)
        ACC_WORD: begin
          lane_we[l]   = aligned;
          lane_data[l] = wr_data[(LANES-1-l)*BYTE_W +: BYTE_W];
        end
        ACC_BYTE: begin
          lane_we[l]   = (ofs == LANE_W'(l));
          lane_data[l] = wr_data[BYTE_W-1:0];
        end
        default: begin
          lane_we[l]   = 1'b0;
          lane_data[l] = wr_data[BYTE_W-1:0];
        end
      endcase
    end
  end

endmodule

// File: rtl/bytemem_array.sv
module bytemem_array
  import bytemem_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ROWS   = 64
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [$clog2(ROWS)-1:0]              row,
  input  logic [DATA_W/BYTE_W-1:0]             lane_we,
  input  logic [DATA_W/BYTE_W-1:0][BYTE_W-1:0] lane_data,
  output logic [DATA_W-1:0]                    rd_data
);

  localparam int LANES = DATA_W / BYTE_W;
  localparam int ROW_W = $clog2(ROWS);

  logic [BYTE_W-1:0] cell_q [ROWS][LANES];
  logic [BYTE_W-1:0] cell_d [ROWS][LANES];
  logic              cell_en[ROWS][LANES];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar l = 0; l < LANES; l++) begin : g_cell
      always_comb begin
        cell_en[r][l] = lane_we[l] && (row == ROW_W'(r));
        cell_d[r][l]  = lane_data[l];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cell_q[r][l] <= '0;
        end else if (cell_en[r][l]) begin
          cell_q[r][l] <= cell_d[r][l];
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_rd
    assign rd_data[(LANES-1-l)*BYTE_W +: BYTE_W] = cell_q[row][l];
  end

endmodule

// File: rtl/bytemem.sv
module bytemem
  import bytemem_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int DEPTH_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_word,
  input  logic              wr_byte,
  output logic [DATA_W-1:0] rd_data,
  output logic              mis_align
);

  localparam int LANES  = DATA_W / BYTE_W;
  localparam int LANE_W = $clog2(LANES);
  localparam int IDX_W  = $clog2(DEPTH_BYTES);
  localparam int ROWS   = DEPTH_BYTES / LANES;
  localparam int ROW_W  = IDX_W - LANE_W;

  logic                          rst_n_sync;
  logic [ROW_W-1:0]              row;
  logic [LANES-1:0]              lane_we;
  logic [LANES-1:0][BYTE_W-1:0]  lane_data;
  logic                          unused_hi;

  assign unused_hi = ^addr[ADDR_W-1:IDX_W];

  bytemem_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  bytemem_ctrl #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W)
  ) u_ctrl (
    .addr_lo   (addr[IDX_W-1:0]),
    .wr_data   (wr_data),
    .wr_word   (wr_word),
    .wr_byte   (wr_byte),
    .row       (row),
    .lane_we   (lane_we),
    .lane_data (lane_data),
    .mis_align (mis_align)
  );

  bytemem_array #(
    .DATA_W (DATA_W),
    .ROWS   (ROWS)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .row       (row),
    .lane_we   (lane_we),
    .lane_data (lane_data),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/bytemem_chk.sv
module bytemem_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_word,
  input logic              wr_byte,
  input logic [DATA_W-1:0] rd_data,
  input logic              mis_align
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [1:0] arm_q;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 2'd0;
    else if (arm_q != 2'd3) arm_q <= arm_q + 2'd1;
  end
  assign armed = (arm_q == 2'd3);

  function automatic logic [7:0] pick(input logic [DATA_W-1:0] w, input logic [LANE_W-1:0] o);
    pick = w[(LANES-1-int'(o))*8 +: 8];
  endfunction

  assert_flag_needs_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mis_align |-> addr[LANE_W-1:0] != '0);

  assert_flag_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_word && !wr_byte && addr[LANE_W-1:0] != '0) |-> mis_align);

  assert_word_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(wr_word && !wr_byte && addr[LANE_W-1:0] == '0) && $stable(addr))
      |-> rd_data == $past(wr_data));

  assert_word_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(wr_word && wr_byte && addr[LANE_W-1:0] == '0) && $stable(addr))
      |-> rd_data == $past(wr_data));

  assert_byte_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(wr_byte && !wr_word) && $stable(addr))
      |-> pick(rd_data, addr[LANE_W-1:0]) == $past(wr_data[7:0]));

  assert_fault_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(wr_word && addr[LANE_W-1:0] != '0) && $stable(addr))
      |-> $stable(rd_data));

endmodule

bind bytemem bytemem_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .addr      (addr),
  .wr_data   (wr_data),
  .wr_word   (wr_word),
  .wr_byte   (wr_byte),
  .rd_data   (rd_data),
  .mis_align (mis_align)
);

// File: tb/tb_bytemem.sv
`timescale 1ns/1ps
module tb_bytemem;

  localparam int DEPTH = 256;

  logic        clk;
  logic        rst_n;
  logic [31:0] addr;
  logic [31:0] wr_data;
  logic        wr_word;
  logic        wr_byte;
  logic [31:0] rd_data;
  logic        mis_align;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] model [DEPTH];

  bytemem #(.ADDR_W(32), .DATA_W(32), .DEPTH_BYTES(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
    .wr_word(wr_word), .wr_byte(wr_byte), .rd_data(rd_data), .mis_align(mis_align)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int base_of(input logic [31:0] a);
    base_of = int'(a[7:0]) & ~3;
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    int b;
    b = base_of(a);
    exp_word = {model[b], model[b+1], model[b+2], model[b+3]};
  endfunction

  function automatic logic exp_flag(input logic [31:0] a, input logic ww, input logic wb);
    exp_flag = (a[1:0] != 2'b00) && (ww || !wb);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // one operation: drive at falling edge, check combinational results, update model at rising edge
  task automatic op(input logic [31:0] a, input logic [31:0] d, input logic ww, input logic wb,
                    input string tag);
    @(negedge clk);
    addr = a; wr_data = d; wr_word = ww; wr_byte = wb;
    #1;
    check(mis_align == exp_flag(a, ww, wb), {tag, " R5 flag"},
          {31'd0, mis_align}, {31'd0, exp_flag(a, ww, wb)});
    if (!ww && !wb)
      check(rd_data == exp_word(a), {tag, " R2 read"}, rd_data, exp_word(a));
    @(posedge clk);
    if (ww) begin
      if (a[1:0] == 2'b00) begin
        for (int k = 0; k < 4; k++) model[base_of(a) + k] = d[31-8*k -: 8];
      end
    end else if (wb) begin
      model[int'(a[7:0])] = d[7:0];
    end
  endtask

  task automatic rd(input logic [31:0] a, input string tag);
    op(a, 32'h0, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
    rst_n = 1'b0; addr = 32'h0; wr_data = 32'hFFFF_FFFF; wr_word = 1'b1; wr_byte = 1'b0;
    // R9: write attempted while reset is held
    repeat (4) @(posedge clk);
    @(negedge clk);
    wr_word = 1'b0; wr_data = 32'h0;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    rd(32'h0000_0000, "R9 write under reset ignored");
    rd(32'h0000_0040, "R1 reset clear");
    rd(32'h0000_00FC, "R1 reset clear top");

    op(32'h1001_0000, 32'h0011_2233, 1'b1, 1'b0, "R3 word write");
    rd(32'h1001_0000, "R3 word readback");
    rd(32'h1001_0002, "R2 unaligned read shows base word");

    op(32'h0000_0010, 32'hAABB_CCDD, 1'b1, 1'b0, "R3 word write");
    op(32'h0000_0012, 32'h1234_5677, 1'b0, 1'b1, "R4 byte lane2");
    rd(32'h0000_0010, "R4 byte lane2 readback");
    check(rd_data == 32'hAABB_77DD, "R4 lane2 only", rd_data, 32'hAABB_77DD);
    op(32'h0000_0013, 32'h0000_00E1, 1'b0, 1'b1, "R4 byte lane3");
    op(32'h0000_0011, 32'h0000_00E2, 1'b0, 1'b1, "R4 byte lane1");
    rd(32'h0000_0010, "R4 multi byte readback");
    check(rd_data == 32'hAAE2_77E1, "R4 byte lanes", rd_data, 32'hAAE2_77E1);

    op(32'h0000_0011, 32'h5555_5555, 1'b1, 1'b0, "R6 faulting word write");
    rd(32'h0000_0010, "R6 contents kept");
    check(rd_data == 32'hAAE2_77E1, "R6 no change", rd_data, 32'hAAE2_77E1);

    op(32'h0000_0020, 32'hCAFE_F00D, 1'b1, 1'b1, "R7 both controls");
    rd(32'h0000_0020, "R7 readback");
    check(rd_data == 32'hCAFE_F00D, "R7 word wins", rd_data, 32'hCAFE_F00D);
    op(32'h0000_0023, 32'h0000_0099, 1'b1, 1'b1, "R7 both unaligned");
    rd(32'h0000_0020, "R7 unaligned both no write");
    check(rd_data == 32'hCAFE_F00D, "R7 R6 unaligned both", rd_data, 32'hCAFE_F00D);

    op(32'h0000_0130, 32'h0BAD_BEEF, 1'b1, 1'b0, "R8 alias write");
    rd(32'h0000_0030, "R8 alias read");
    check(rd_data == 32'h0BAD_BEEF, "R8 aliasing", rd_data, 32'h0BAD_BEEF);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, d;
      logic [1:0]  kind;
      a = $urandom();
      d = $urandom();
      kind = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) != 0 && kind == 2'd1) a[1:0] = 2'b00;
      case (kind)
        2'd0: op(a, d, 1'b0, 1'b0, "R2 random read");
        2'd1: op(a, d, 1'b1, 1'b0, "R3 random word");
        2'd2: op(a, d, 1'b0, 1'b1, "R4 random byte");
        default: op(a, d, 1'b1, 1'b1, "R7 random both");
      endcase
    end
    for (int i = 0; i < DEPTH; i += 4) rd(32'(i), "R2 final sweep");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule